// File: doc/BRIEF.md
# Serial Configuration Loader for a Downstream FPGA

This block brings up a second FPGA that takes its bitstream over a two-wire serial link (a data line plus a configuration clock). It fetches an image from a byte-wide store through a simple request/valid read port. The image opens with an eight-byte header: a 32-bit tag word, then a 32-bit byte count, both big-endian. The loader rejects the image before touching the target if the tag is wrong or the count is too large.

After the header is accepted, the loader takes over the target's program, clock and data pins. It resets the target with a low pulse on the program line, waits for the target to clear its memory, and checks that the target's init line is high. It then streams the payload MSB first, one clock pulse per bit, and checks the init line after every byte. When the payload is done, it keeps clocking all-ones bytes until the target raises its done line. It then clocks exactly one more all-ones byte and reports success. If the done line does not rise within a bounded time, it reports a timeout instead.

All delays are parameters counted in system-clock cycles. A 3-bit result code tells the failure modes apart.

Top module: `cfgLoader`

## Requirements
- R1: The header is read from addresses 0 to 7 and the payload from address 8 upward, strictly in order. Each request holds `rdReq` high with a stable `rdAddr` until `rdValid` is seen. Bytes 0..3 form the tag word (MSB first) and bytes 4..7 form the length.
- R2: If the tag word is not `MAGIC` (default 0x53415231), the run ends with `errCode`=1. The output enables never assert and no clock pulse is issued.
- R3: A length above `MAX_LEN` ends the run with `errCode`=2 and no clock pulse. A length equal to `MAX_LEN` is accepted.
- R4: After an accepted header, `progBOe`, `cclkOe` and `dinOe` go high. `progB` is held low for exactly `PROG_LOW_CYC` cycles while `cclk` and `din` are low, and `progB` is then released high.
- R5: `INIT_WAIT_CYC` cycles after the release, `initB` is sampled. If it is low, the run ends with `errCode`=3 and no clock pulse.
- R6: Every shifted byte goes out MSB first. Each bit has `cclk` low for `HALF_CYC` cycles with `din` set, then high for `HALF_CYC` cycles with `din` unchanged. Payload bytes appear in address order.
- R7: `initB` is sampled after each completed byte. If it is low, the run ends with `errCode`=4 and no further byte is clocked.
- R8: After the payload, 0xFF bytes are clocked for as long as `done` is low. Once `done` is seen high, exactly one more 0xFF byte is clocked. Then `ok` goes high, `cclk` is low and `progB` is high. A zero-length payload goes straight to this phase.
- R9: If `done` is still low when `DONE_TIMEOUT_CYC` cycles have elapsed since the end of the payload, the run ends with `errCode`=5.
- R10: `busy` is high from the cycle after `start` until the run ends. A `start` while busy is ignored. `errCode` and `ok` hold their values until the next accepted `start`, which clears both. `ok` and a nonzero `errCode` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins a load when idle |
| rdAddr | output | ADDR_W | Byte address into the image store |
| rdReq | output | 1 | Read request, held until `rdValid` |
| rdData | input | 8 | Byte returned by the store |
| rdValid | input | 1 | `rdData` is valid for the current request |
| progB | output | 1 | Target program line (active low) |
| progBOe | output | 1 | Output enable for `progB` |
| cclk | output | 1 | Configuration clock to the target |
| cclkOe | output | 1 | Output enable for `cclk` |
| din | output | 1 | Serial configuration data |
| dinOe | output | 1 | Output enable for `din` |
| initB | input | 1 | Target init/error line (low = not ready or error) |
| done | input | 1 | Target configuration-complete line |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load completed successfully |
| errCode | output | 3 | 0 none, 1 bad tag, 2 too long, 3 no init, 4 init low during load, 5 done timeout |

## Verification
The byte stream is reconstructed from `din` at each rising `cclk` and compared with a queue of expected bytes. The payloads mix zero and all-ones patterns, so a bit-order swap or a dropped bit shows as a mismatch. The runs vary the header (wrong tag, length one above the limit, length exactly at the limit, zero length) to separate the reject paths from the accept path. They also vary when `done` rises (already high, on the last payload byte, several fillers later, never) to pin the filler count and the single trailing byte. Other runs pull `initB` low before shifting or after a chosen byte, and send a second `start` mid-run, so that each error code and the ignored strobe are told apart.

// File: rtl/cfgLoaderPkg.sv
package cfgLoaderPkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_MAGIC   = 3'd1,
    ERR_LENGTH  = 3'd2,
    ERR_NOINIT  = 3'd3,
    ERR_CRC     = 3'd4,
    ERR_TIMEOUT = 3'd5
  } errCode_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic hdrShift;
    logic loadData;
    logic loadFill;
  } ctrlStrb_t;

endpackage

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgLoaderPkg::*;
#(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned HALF_CYC = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       magicWord,
  output logic [31:0]       lenWord,
  output logic              shiftBusy,
  output logic              cclk,
  output logic              din
);
  localparam int unsigned HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HC_W-1:0] HALF_LAST = HC_W'(HALF_CYC - 1);

  logic [63:0]       hdrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        shReg;
  logic [2:0]        bitCnt;
  logic [HC_W-1:0]   halfCnt;
  logic              active;
  logic              phaseHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ  <= '0;
      addrQ <= '0;
    end else begin
      if (strb.hdrShift) hdrQ <= {hdrQ[55:0], rdData};
      if (strb.clrAddr)      addrQ <= '0;
      else if (strb.incAddr) addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      bitCnt  <= '0;
      halfCnt <= '0;
      active  <= 1'b0;
      phaseHi <= 1'b0;
    end else if (strb.loadData || strb.loadFill) begin
      shReg   <= strb.loadData ? rdData : 8'hFF;
      bitCnt  <= '0;
      halfCnt <= '0;
      active  <= 1'b1;
      phaseHi <= 1'b0;
    end else if (active) begin
      if (halfCnt == HALF_LAST) begin
        halfCnt <= '0;
        if (!phaseHi) begin
          phaseHi <= 1'b1;
        end else begin
          phaseHi <= 1'b0;
          shReg   <= {shReg[6:0], 1'b0};
          if (bitCnt == 3'd7) active <= 1'b0;
          else                bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign addr      = addrQ;
  assign magicWord = hdrQ[63:32];
  assign lenWord   = hdrQ[31:0];
  assign shiftBusy = active;
  assign cclk      = active & phaseHi;
  assign din       = shReg[7];

  // R6: data must not move while the clock is high
  a_r6_din_stable: assert property (@(posedge clk) disable iff (!rstN)
    cclk |-> $stable(din));

  // R6: a fresh byte is never loaded on top of one still being shifted
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    active |-> !(strb.loadData || strb.loadFill));

endmodule

// File: rtl/cfgControl.sv
module cfgControl
  import cfgLoaderPkg::*;
#(
  parameter int unsigned ADDR_W           = 22,
  parameter logic [31:0] MAGIC            = 32'h5341_5231,
  parameter int unsigned MAX_LEN          = 32'h0022_0000,
  parameter int unsigned PROG_LOW_CYC     = 25,
  parameter int unsigned INIT_WAIT_CYC    = 500_000,
  parameter int unsigned DONE_TIMEOUT_CYC = 10_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              rdValid,
  input  logic              initB,
  input  logic              done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       magicWord,
  input  logic [31:0]       lenWord,
  input  logic              shiftBusy,
  output ctrlStrb_t         strb,
  output logic              rdReq,
  output logic              progB,
  output logic              oe,
  output logic              busy,
  output logic              ok,
  output errCode_t          errCode
);
  localparam int unsigned MAX_A = (PROG_LOW_CYC > INIT_WAIT_CYC) ? PROG_LOW_CYC : INIT_WAIT_CYC;
  localparam int unsigned MAX_T = (MAX_A > DONE_TIMEOUT_CYC) ? MAX_A : DONE_TIMEOUT_CYC;
  localparam int unsigned TMR_W = $clog2(MAX_T + 1);
  localparam logic [TMR_W-1:0] T_PLOW = TMR_W'(PROG_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] T_INIT = TMR_W'(INIT_WAIT_CYC - 1);
  localparam logic [TMR_W-1:0] T_DONE = TMR_W'(DONE_TIMEOUT_CYC);
  localparam logic [ADDR_W-1:0] HDR_LAST = ADDR_W'(7);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_CHECK, S_PLOW, S_PWAIT,
    S_FETCH, S_SHIFT, S_POLL, S_FILL, S_TRAIL
  } state_t;

  state_t            state;
  logic [TMR_W-1:0]  tmr;
  logic              progBQ, oeQ, okQ;
  errCode_t          errQ;
  logic [ADDR_W-1:0] endAddr;

  assign endAddr = lenWord[ADDR_W-1:0] + ADDR_W'(8);

  always_comb begin
    strb  = '0;
    rdReq = 1'b0;
    unique case (state)
      S_IDLE:  strb.clrAddr = start;
      S_HDR: begin
        rdReq = 1'b1;
        strb.hdrShift = rdValid;
        strb.incAddr  = rdValid;
      end
      S_FETCH: begin
        rdReq = 1'b1;
        strb.loadData = rdValid;
        strb.incAddr  = rdValid;
      end
      S_POLL:  strb.loadFill = done || (tmr != '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tmr    <= '0;
      progBQ <= 1'b1;
      oeQ    <= 1'b0;
      okQ    <= 1'b0;
      errQ   <= ERR_NONE;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          okQ   <= 1'b0;
          errQ  <= ERR_NONE;
          state <= S_HDR;
        end
        S_HDR: if (rdValid && addr == HDR_LAST) state <= S_CHECK;
        S_CHECK: begin
          if (magicWord != MAGIC) begin
            errQ  <= ERR_MAGIC;
            state <= S_IDLE;
          end else if (lenWord > 32'(MAX_LEN)) begin
            errQ  <= ERR_LENGTH;
            state <= S_IDLE;
          end else begin
            oeQ    <= 1'b1;
            progBQ <= 1'b0;
            tmr    <= T_PLOW;
            state  <= S_PLOW;
          end
        end
        S_PLOW: begin
          if (tmr == '0) begin
            progBQ <= 1'b1;
            tmr    <= T_INIT;
            state  <= S_PWAIT;
          end else tmr <= tmr - 1'b1;
        end
        S_PWAIT: begin
          if (tmr == '0) begin
            if (!initB) begin
              errQ  <= ERR_NOINIT;
              state <= S_IDLE;
            end else if (lenWord == '0) begin
              tmr   <= T_DONE;
              state <= S_POLL;
            end else state <= S_FETCH;
          end else tmr <= tmr - 1'b1;
        end
        S_FETCH: if (rdValid) state <= S_SHIFT;
        S_SHIFT: if (!shiftBusy) begin
          if (!initB) begin
            errQ  <= ERR_CRC;
            state <= S_IDLE;
          end else if (addr == endAddr) begin
            tmr   <= T_DONE;
            state <= S_POLL;
          end else state <= S_FETCH;
        end
        S_POLL: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          if (done)              state <= S_TRAIL;
          else if (tmr == '0) begin
            errQ  <= ERR_TIMEOUT;
            state <= S_IDLE;
          end else               state <= S_FILL;
        end
        S_FILL: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          if (!shiftBusy) state <= S_POLL;
        end
        S_TRAIL: if (!shiftBusy) begin
          okQ   <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign progB   = progBQ;
  assign oe      = oeQ;
  assign busy    = (state != S_IDLE);
  assign ok      = okQ;
  assign errCode = errQ;

  // R1: a pending read keeps its address
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(addr)));

  // R4: the program pulse is only ever driven, never floated low
  a_r4_progb_driven: assert property (@(posedge clk) disable iff (!rstN)
    !progBQ |-> oeQ);

  // R10: success and a failure code never coexist
  a_r10_ok_xor_err: assert property (@(posedge clk) disable iff (!rstN)
    (errQ != ERR_NONE) |-> !okQ);

  // R10: results stay put while idle without a start
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(errQ) && $stable(okQ)));

endmodule

// File: rtl/cfgLoader.sv
module cfgLoader
  import cfgLoaderPkg::*;
#(
  parameter int unsigned ADDR_W           = 22,
  parameter logic [31:0] MAGIC            = 32'h5341_5231,
  parameter int unsigned MAX_LEN          = 32'h0022_0000,
  parameter int unsigned HALF_CYC         = 9,
  parameter int unsigned PROG_LOW_CYC     = 25,
  parameter int unsigned INIT_WAIT_CYC    = 500_000,
  parameter int unsigned DONE_TIMEOUT_CYC = 10_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdReq,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output logic              progB,
  output logic              progBOe,
  output logic              cclk,
  output logic              cclkOe,
  output logic              din,
  output logic              dinOe,
  input  logic              initB,
  input  logic              done,
  output logic              busy,
  output logic              ok,
  output logic [2:0]        errCode
);
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       magicWord, lenWord;
  logic              shiftBusy, oe;
  errCode_t          errQ;

  cfgDatapath #(.ADDR_W(ADDR_W), .HALF_CYC(HALF_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData),
    .addr(addr), .magicWord(magicWord), .lenWord(lenWord),
    .shiftBusy(shiftBusy), .cclk(cclk), .din(din)
  );

  cfgControl #(
    .ADDR_W(ADDR_W), .MAGIC(MAGIC), .MAX_LEN(MAX_LEN),
    .PROG_LOW_CYC(PROG_LOW_CYC), .INIT_WAIT_CYC(INIT_WAIT_CYC),
    .DONE_TIMEOUT_CYC(DONE_TIMEOUT_CYC)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .rdValid(rdValid),
    .initB(initB), .done(done), .addr(addr), .magicWord(magicWord),
    .lenWord(lenWord), .shiftBusy(shiftBusy), .strb(strb), .rdReq(rdReq),
    .progB(progB), .oe(oe), .busy(busy), .ok(ok), .errCode(errQ)
  );

  assign rdAddr  = addr;
  assign progBOe = oe;
  assign cclkOe  = oe;
  assign dinOe   = oe;
  assign errCode = errQ;

  // R6: no clock pulse outside a run
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cclk);

  // R6: program line stays released while bits are clocked
  a_r6_progb_high_shift: assert property (@(posedge clk) disable iff (!rstN)
    cclk |-> (progB && cclkOe));

endmodule

// File: tb/cfgLoader_tb_top.sv
module cfgLoader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int HALF = 2;
  localparam int PLOW = 5;
  localparam int IWAIT = 20;
  localparam int DTO = 300;
  localparam int MAXL = 16;
  localparam logic [31:0] TAG = 32'h5341_5231;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] rdAddr;
  logic rdReq;
  logic [7:0] rdData = '0;
  logic rdValid = 1'b0;
  logic progB, progBOe, cclk, cclkOe, din, dinOe;
  logic initBIn = 1'b1;
  logic doneIn = 1'b0;
  logic busy, ok;
  logic [2:0] errCode;

  cfgLoader #(
    .ADDR_W(ADDR_W), .MAX_LEN(MAXL), .HALF_CYC(HALF), .PROG_LOW_CYC(PLOW),
    .INIT_WAIT_CYC(IWAIT), .DONE_TIMEOUT_CYC(DTO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .rdAddr(rdAddr), .rdReq(rdReq),
    .rdData(rdData), .rdValid(rdValid), .progB(progB), .progBOe(progBOe),
    .cclk(cclk), .cclkOe(cclkOe), .din(din), .dinOe(dinOe),
    .initB(initBIn), .done(doneIn), .busy(busy), .ok(ok), .errCode(errCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [0:255];
  logic [7:0] expQ [$];
  int rcvCnt, extraCnt, doneAt, initFailAt, lowCnt, lowBad, widthBad, hiCnt, addrBad, nextAddr;
  int waitCnt = 0, readNo = 0, cyc = 0;
  logic oeSeen;
  logic [7:0] capByte = '0;
  int capBits = 0;

  task automatic check(input logic cond, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // image store model with varying latency; checks the read order (R1)
  always @(negedge clk) begin
    if (rdValid) rdValid = 1'b0;
    else if (rdReq) begin
      if (waitCnt >= (readNo % 3)) begin
        if (int'(rdAddr) != nextAddr) addrBad++;
        nextAddr++;
        rdData = mem[rdAddr];
        rdValid = 1'b1;
        waitCnt = 0;
        readNo++;
      end else waitCnt++;
    end
  end

  // pin monitor: program pulse length, output enables, clock high width
  always @(negedge clk) begin
    if (progBOe) oeSeen = 1'b1;
    if (!progB) begin
      lowCnt++;
      if (cclk || din || !progBOe || !cclkOe || !dinOe) lowBad++;
    end
    if (cclk) hiCnt++;
    else if (hiCnt != 0) begin
      if (hiCnt != HALF) widthBad++;
      hiCnt = 0;
    end
  end

  // scoreboard monitor: target side, rebuilds bytes on rising cclk
  always @(posedge cclk) begin
    capByte = {capByte[6:0], din};
    capBits++;
    if (capBits == 8) begin
      capBits = 0;
      rcvCnt++;
      if (expQ.size() > 0) begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(capByte == e, "R6 payload byte order/value", capByte, e);
      end else begin
        extraCnt++;
        check(capByte == 8'hFF, "R8 filler byte", capByte, 8'hFF);
      end
      if (rcvCnt == doneAt) doneIn = 1'b1;
      if (rcvCnt == initFailAt) initBIn = 1'b0;
    end
  end

  // driver: builds image, pushes expected bytes, runs a load
  task automatic runLoad(input logic [31:0] tag, input int len, input int dAt,
                         input int fAt, input logic initOk, input int seed, input int midStart);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + seed);
    mem[8] = 8'h00; mem[9] = 8'hFF; mem[10] = 8'h81;
    for (int i = 0; i < 4; i++) begin
      mem[i]   = tag[31-8*i -: 8];
      mem[4+i] = 8'(len >> (24 - 8*i));
    end
    expQ.delete();
    if (tag == TAG && len <= MAXL && initOk)
      for (int i = 0; i < len; i++)
        if (fAt < 0 || i < fAt) expQ.push_back(mem[8+i]);
    rcvCnt = 0; extraCnt = 0; lowCnt = 0; lowBad = 0; widthBad = 0; hiCnt = 0;
    addrBad = 0; nextAddr = 0; oeSeen = 1'b0; capBits = 0;
    doneAt = dAt; initFailAt = fAt;
    doneIn = (dAt == 0);
    initBIn = initOk;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1 && errCode == 3'd0 && ok == 1'b0, "R10 start clears result, busy high", {busy, errCode, ok}, 5'b10000);
    if (midStart > 0) begin
      repeat (midStart) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !ok && errCode == 0 && !progBOe && !cclk && !rdReq && progB,
          "R10 reset state", {busy, ok, errCode, progBOe, cclk, rdReq}, 0);

    // R2: wrong tag
    runLoad(32'h5341_5232, 4, 100, -1, 1'b1, 3, 0);
    check(errCode == 3'd1, "R2 bad tag code", errCode, 1);
    check(!oeSeen && rcvCnt == 0, "R2 target untouched", rcvCnt, 0);
    check(addrBad == 0 && nextAddr == 8, "R1 header reads in order", nextAddr, 8);

    // R3: one above the limit
    runLoad(TAG, MAXL + 1, 100, -1, 1'b1, 5, 0);
    check(errCode == 3'd2, "R3 too long code", errCode, 2);
    check(rcvCnt == 0 && lowCnt == 0, "R3 no pulse/no clock", rcvCnt, 0);

    // R5: target never ready
    runLoad(TAG, 4, 100, -1, 1'b0, 7, 0);
    check(errCode == 3'd3, "R5 no-init code", errCode, 3);
    check(rcvCnt == 0, "R5 no bytes clocked", rcvCnt, 0);
    check(lowCnt == PLOW && lowBad == 0, "R4 program pulse width/levels", lowCnt, PLOW);
    check(progB == 1'b1, "R4 program released", progB, 1);

    // R8 main: done after three fillers
    runLoad(TAG, 5, 8, -1, 1'b1, 11, 0);
    check(ok && errCode == 0, "R8 success flag", {ok, errCode}, 8);
    check(rcvCnt == 9 && extraCnt == 4, "R8 fillers plus one trailing", extraCnt, 4);
    check(expQ.size() == 0, "R6 all payload seen", expQ.size(), 0);
    check(widthBad == 0, "R6 clock high width", widthBad, 0);
    check(lowCnt == PLOW && lowBad == 0, "R4 program pulse width/levels", lowCnt, PLOW);
    check(addrBad == 0 && nextAddr == 13, "R1 payload reads in order", nextAddr, 13);
    check(!cclk && progB, "R8 final pin levels", {cclk, progB}, 1);

    // R3 boundary: exactly at limit, done on last payload byte
    runLoad(TAG, MAXL, MAXL, -1, 1'b1, 13, 0);
    check(ok && errCode == 0, "R3 limit length accepted", errCode, 0);
    check(rcvCnt == MAXL + 1 && extraCnt == 1, "R8 single trailing byte", extraCnt, 1);

    // R7: init drops after second byte
    runLoad(TAG, 6, 100, 2, 1'b1, 17, 0);
    check(errCode == 3'd4, "R7 load error code", errCode, 4);
    check(rcvCnt == 2 && !ok, "R7 no byte after error", rcvCnt, 2);

    // R9: done never rises
    runLoad(TAG, 2, 100000, -1, 1'b1, 19, 0);
    check(errCode == 3'd5, "R9 timeout code", errCode, 5);
    check(extraCnt >= 7 && extraCnt <= 11, "R9 fillers during timeout window", extraCnt, 9);
    repeat (50) @(negedge clk);
    check(errCode == 3'd5 && !busy, "R10 error held while idle", errCode, 5);

    // R10: second start mid-run ignored
    runLoad(TAG, 6, 7, -1, 1'b1, 23, 60);
    check(ok && errCode == 0, "R10 mid-run start ignored", errCode, 0);
    check(rcvCnt == 8 && extraCnt == 2, "R10 byte count unchanged", rcvCnt, 8);
    check(addrBad == 0, "R1 no restart of reads", addrBad, 0);

    // R8: zero-length payload with done already high
    runLoad(TAG, 0, 0, -1, 1'b1, 29, 0);
    check(ok && rcvCnt == 1 && extraCnt == 1, "R8 zero length single trailing byte", rcvCnt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule